// File: doc/BRIEF.md
# Feeder and Mold-Door Sequence Controller

This block sequences one station of a block-transport chain: a feeder arm that pushes an incoming block against a mold door, and the door itself. It reads a block-presence sensor, a door-closed sensor and a level "at target" flag per axis. It runs a request/acknowledge exchange with the belt upstream and another with the extractor downstream. From these it selects the setpoint each axis is commanded to. Loop control and motor drive sit outside the block.

After reset both axes home. The block then waits for a block from the belt and takes it. It confirms that the door is shut and pushes the block against it. It then dwells while molding takes place, pulls the feeder back home, and only after that opens the door. It offers the block forward and keeps the door open until the extractor confirms removal, then closes the door. Every motion state has a watchdog with a limit set at a port. A watchdog expiry or an external fault drives the station into a latched safe state: the feeder goes home, the door opens and the belt is told to stop.

Top module: `feed_door_seq`

## Requirements
- R1: Command encodings are feeder 0=hold, 1=home, 2=push and door 0=hold, 1=close, 2=open. During and after reset the feeder is commanded home and the door closed, with `feederHome` and `faultOut` low. This holds until `feedDone` and `doorDone` are high in the same cycle.
- R2: When idle, both commands are hold and `feederHome` is high. This persists with no block offered.
- R3: `prevAck` is high, combinationally, only while idle with both `prevReq` and `blkSensor` high. That cycle accepts the block, and `feederHome` falls on the next cycle.
- R4: After a block is accepted the feeder holds until `doorClosed` is seen high. Push is commanded on the following cycle.
- R5: Once push is done, both axes hold for exactly MOLD_TICKS cycles. The feeder is then commanded home, and the door stays at hold until that retract is done. It is then commanded open, with `feederHome` high.
- R6: After the door-open motion is done, `xferReq` is held high with the door at hold until `xferAck` is seen. The door is then commanded closed. When the close is done the block is idle again.
- R7: In each motion state (home, push, retract, open, close) the cycle count since entry starts at 0. If the axis done flag is absent at count `wdLimit`, a fault follows on the next cycle. A done flag at that count still advances normally.
- R8: A fault, from `faultIn` or from R7, commands the feeder home and the door open. It raises `beltStop` and `faultOut`, drops `prevAck` and `xferReq`, and stays latched until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blkSensor | input | 1 | Block present at feeder |
| prevReq | input | 1 | Upstream belt offers a block |
| prevAck | output | 1 | Block taken from upstream |
| feederHome | output | 1 | Feeder at home, belt may deliver |
| beltStop | output | 1 | Upstream must stop supplying blocks |
| doorClosed | input | 1 | Door-closed sensor |
| xferReq | output | 1 | Block available at open door |
| xferAck | input | 1 | Extractor has removed block |
| feedDone | input | 1 | Feeder axis at its setpoint |
| doorDone | input | 1 | Door axis at its setpoint |
| faultIn | input | 1 | External feeder fault |
| wdLimit | input | CNT_W | Watchdog limit in cycles |
| feedCmd | output | 2 | Feeder setpoint selection |
| doorCmd | output | 2 | Door setpoint selection |
| faultOut | output | 1 | Latched fault |

## Verification
The bench targets the watchdog boundary by sweeping done latency against limit. A done flag arriving exactly at the limit must win, one cycle later it must fault; an off-by-one counter would fault early or late by one step. Per-cycle command checks cover the ordering hazards. These are a push before the door is confirmed shut, a door opening while the feeder is still out, and a door closing before the extractor acknowledges. Any of these would be a mechanical collision or a lost block. The mold dwell length is also checked per cycle. Fault tests confirm that the safe state latches after `faultIn` drops and that it withdraws an outstanding forward offer.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {FC_HOLD = 2'd0, FC_HOME = 2'd1, FC_PUSH = 2'd2} feedCmd_e;
  typedef enum logic [1:0] {DC_HOLD = 2'd0, DC_CLOSE = 2'd1, DC_OPEN = 2'd2} doorCmd_e;

  typedef enum logic [3:0] {
    S_HOME, S_IDLE, S_CHK, S_PUSH, S_MOLD, S_RETRACT,
    S_OPEN, S_OFFER, S_CLOSE, S_FAULT
  } seqState_e;

  typedef struct packed {
    logic clr;
  } ctrlStrobe_t;

  typedef struct packed {
    logic wdHit;
    logic dwellHit;
  } dpStatus_t;

endpackage

// File: rtl/seq_dpath.sv
module seq_dpath
  import seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MOLD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strb,
  input  logic [CNT_W-1:0] wdLimit,
  output dpStatus_t        st
);

  localparam logic [CNT_W-1:0] MOLD_LAST = CNT_W'(MOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || strb.clr) begin
      cnt <= '0;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    st.wdHit    = (cnt == wdLimit);
    st.dwellHit = (cnt == MOLD_LAST);
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blkSensor,
  input  logic        prevReq,
  input  logic        doorClosed,
  input  logic        xferAck,
  input  logic        feedDone,
  input  logic        doorDone,
  input  logic        faultIn,
  input  dpStatus_t   st,
  output ctrlStrobe_t strb,
  output logic [1:0]  feedCmd,
  output logic [1:0]  doorCmd,
  output logic        prevAck,
  output logic        xferReq,
  output logic        feederHome,
  output logic        beltStop,
  output logic        faultOut
);

  seqState_e state, nextState;
  logic inMotion, axisDone;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_HOME;
    else        state <= nextState;
  end

  always_comb begin
    inMotion = 1'b0;
    axisDone = 1'b0;
    unique case (state)
      S_HOME:              begin inMotion = 1'b1; axisDone = feedDone && doorDone; end
      S_PUSH, S_RETRACT:   begin inMotion = 1'b1; axisDone = feedDone; end
      S_OPEN, S_CLOSE:     begin inMotion = 1'b1; axisDone = doorDone; end
      default:             ;
    endcase
  end

  always_comb begin
    nextState = state;
    if (faultIn) begin
      nextState = S_FAULT;
    end else if (inMotion) begin
      if (axisDone) begin
        unique case (state)
          S_HOME:    nextState = S_IDLE;
          S_PUSH:    nextState = S_MOLD;
          S_RETRACT: nextState = S_OPEN;
          S_OPEN:    nextState = S_OFFER;
          default:   nextState = S_IDLE;
        endcase
      end else if (st.wdHit) begin
        nextState = S_FAULT;
      end
    end else begin
      unique case (state)
        S_IDLE:  if (prevReq && blkSensor) nextState = S_CHK;
        S_CHK:   if (doorClosed)           nextState = S_PUSH;
        S_MOLD:  if (st.dwellHit)          nextState = S_RETRACT;
        S_OFFER: if (xferAck)              nextState = S_CLOSE;
        default: ;
      endcase
    end
  end

  assign strb.clr = (nextState != state);

  always_comb begin
    feedCmd    = FC_HOLD;
    doorCmd    = DC_HOLD;
    xferReq    = 1'b0;
    feederHome = 1'b0;
    beltStop   = 1'b0;
    faultOut   = 1'b0;
    unique case (state)
      S_HOME:    begin feedCmd = FC_HOME; doorCmd = DC_CLOSE; end
      S_IDLE:    feederHome = 1'b1;
      S_PUSH:    feedCmd = FC_PUSH;
      S_RETRACT: feedCmd = FC_HOME;
      S_OPEN:    begin doorCmd = DC_OPEN; feederHome = 1'b1; end
      S_OFFER:   begin xferReq = 1'b1; feederHome = 1'b1; end
      S_CLOSE:   begin doorCmd = DC_CLOSE; feederHome = 1'b1; end
      S_FAULT:   begin feedCmd = FC_HOME; doorCmd = DC_OPEN; beltStop = 1'b1; faultOut = 1'b1; end
      default:   ;
    endcase
  end

  assign prevAck = (state == S_IDLE) && prevReq && blkSensor && !faultIn;

  assert_ack_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prevAck |-> (feederHome && blkSensor && prevReq));

  assert_push_after_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (feedCmd == FC_PUSH && $past(feedCmd) != FC_PUSH) |-> $past(doorClosed));

  assert_no_open_while_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(feedCmd == FC_PUSH && doorCmd == DC_OPEN));

  assert_offer_after_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xferReq) |-> ($past(doorDone) && $past(doorCmd) == DC_OPEN));

  assert_wd_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(faultOut) && !$past(faultIn)) |-> $past(st.wdHit));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    faultOut |=> (faultOut && beltStop && !xferReq));

endmodule

// File: rtl/feed_door_seq.sv
module feed_door_seq
  import seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int MOLD_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blkSensor,
  input  logic             prevReq,
  output logic             prevAck,
  output logic             feederHome,
  output logic             beltStop,
  input  logic             doorClosed,
  output logic             xferReq,
  input  logic             xferAck,
  input  logic             feedDone,
  input  logic             doorDone,
  input  logic             faultIn,
  input  logic [CNT_W-1:0] wdLimit,
  output logic [1:0]       feedCmd,
  output logic [1:0]       doorCmd,
  output logic             faultOut
);

  ctrlStrobe_t strb;
  dpStatus_t   st;

  seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .blkSensor(blkSensor), .prevReq(prevReq),
    .doorClosed(doorClosed), .xferAck(xferAck), .feedDone(feedDone),
    .doorDone(doorDone), .faultIn(faultIn), .st(st), .strb(strb),
    .feedCmd(feedCmd), .doorCmd(doorCmd), .prevAck(prevAck),
    .xferReq(xferReq), .feederHome(feederHome), .beltStop(beltStop),
    .faultOut(faultOut)
  );

  seq_dpath #(.CNT_W(CNT_W), .MOLD_TICKS(MOLD_TICKS)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdLimit(wdLimit), .st(st)
  );

endmodule

// File: tb/test_feed_door_seq.sv
`timescale 1ns/1ps
module test_feed_door_seq;

  localparam int CNT_W = 8;
  localparam int MOLD  = 4;

  logic clk = 1'b0;
  logic rst_n, blkSensor, prevReq, doorClosed, xferAck, feedDone, doorDone, faultIn;
  logic [CNT_W-1:0] wdLimit;
  logic prevAck, feederHome, beltStop, xferReq, faultOut;
  logic [1:0] feedCmd, doorCmd;

  int vectors = 0;
  int fails   = 0;

  always #4 clk = ~clk;

  feed_door_seq #(.CNT_W(CNT_W), .MOLD_TICKS(MOLD)) i_feed_door_seq (
    .clk(clk), .rst_n(rst_n), .blkSensor(blkSensor), .prevReq(prevReq),
    .prevAck(prevAck), .feederHome(feederHome), .beltStop(beltStop),
    .doorClosed(doorClosed), .xferReq(xferReq), .xferAck(xferAck),
    .feedDone(feedDone), .doorDone(doorDone), .faultIn(faultIn),
    .wdLimit(wdLimit), .feedCmd(feedCmd), .doorCmd(doorCmd), .faultOut(faultOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkCmd(input int ef, input int ed, input string tag);
    chk(feedCmd == 2'(ef), {tag, " feedCmd"}, feedCmd, ef);
    chk(doorCmd == 2'(ed), {tag, " doorCmd"}, doorCmd, ed);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input int wd);
    @(negedge clk);
    rst_n = 1'b0; blkSensor = 0; prevReq = 0; doorClosed = 0; xferAck = 0;
    feedDone = 0; doorDone = 0; faultIn = 0; wdLimit = CNT_W'(wd);
    tick(); tick();
    chkCmd(1, 1, "R1 in reset");
    rst_n = 1'b1;
    chk(faultOut == 0 && feederHome == 0, "R1 status after reset", {faultOut, feederHome}, 0);
  endtask

  task automatic motion(input int lat, input bit useF, input bit useD,
                        input int ef, input int ed, input string tag);
    for (int i = 0; i < lat; i++) begin
      chkCmd(ef, ed, tag);
      tick();
    end
    chkCmd(ef, ed, tag);
    feedDone = useF; doorDone = useD;
    tick();
    feedDone = 0; doorDone = 0;
  endtask

  task automatic takeBlock();
    prevReq = 1; blkSensor = 1; #1;
    chk(prevAck == 1, "R3 ack with req and sensor", prevAck, 1);
    tick();
    prevReq = 0; blkSensor = 0;
    chk(feederHome == 0, "R3 feederHome drops after accept", feederHome, 0);
  endtask

  task automatic fullCycle(input int lat);
    chkCmd(0, 0, "R2 idle");
    chk(feederHome == 1, "R2 idle feederHome", feederHome, 1);
    tick();
    chkCmd(0, 0, "R2 idle persists");
    prevReq = 1; blkSensor = 0; #1;
    chk(prevAck == 0, "R3 no ack without sensor", prevAck, 0);
    tick();
    chk(feederHome == 1, "R3 still idle", feederHome, 1);
    takeBlock();
    for (int i = 0; i < lat; i++) begin
      chkCmd(0, 0, "R4 wait for door closed");
      tick();
    end
    doorClosed = 1;
    tick();
    doorClosed = 0;
    chk(feedCmd == 2'd2, "R4 push after closed", feedCmd, 2);
    motion(lat, 1, 0, 2, 0, "R4 push");
    for (int i = 0; i < MOLD; i++) begin
      chkCmd(0, 0, "R5 mold dwell");
      tick();
    end
    motion(lat, 1, 0, 1, 0, "R5 retract, door held");
    chk(feederHome == 1, "R5 feederHome while opening", feederHome, 1);
    motion(lat, 0, 1, 0, 2, "R6 door open");
    for (int i = 0; i < 2; i++) begin
      chk(xferReq == 1, "R6 offer held", xferReq, 1);
      chkCmd(0, 0, "R6 door held during offer");
      tick();
    end
    xferAck = 1;
    tick();
    xferAck = 0;
    chk(xferReq == 0, "R6 offer withdrawn after ack", xferReq, 0);
    motion(lat, 0, 1, 0, 1, "R6 door close");
  endtask

  task automatic chkFault(input string tag);
    chk(faultOut == 1, {tag, " faultOut"}, faultOut, 1);
    chk(beltStop == 1, {tag, " beltStop"}, beltStop, 1);
    chkCmd(1, 2, tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    doReset(8);
    motion(2, 1, 1, 1, 1, "R1 homing");
    for (int lat = 0; lat < 4; lat++) fullCycle(lat);

    // R7 sweep in push: fault exactly when latency exceeds limit
    for (int w = 1; w < 4; w++) begin
      for (int lat = 0; lat < 5; lat++) begin
        doReset(w);
        motion(0, 1, 1, 1, 1, "R1 homing");
        takeBlock();
        doorClosed = 1; tick(); doorClosed = 0;
        for (int i = 0; ; i++) begin
          if (i == lat) begin
            feedDone = 1; tick(); feedDone = 0;
            chk(faultOut == 0, "R7 done in time", faultOut, 0);
            chkCmd(0, 0, "R7 entered dwell");
            break;
          end else if (i == w) begin
            tick();
            chkFault("R7 push watchdog");
            break;
          end
          chk(faultOut == 0, "R7 no early fault", faultOut, 0);
          tick();
        end
      end
    end

    // R7 in homing
    doReset(2);
    for (int i = 0; i < 3; i++) begin
      chk(faultOut == 0, "R7 homing before limit", faultOut, 0);
      tick();
    end
    chkFault("R7 homing watchdog");

    // R8 external fault in idle, latched
    doReset(8);
    motion(0, 1, 1, 1, 1, "R1 homing");
    faultIn = 1; tick(); faultIn = 0;
    chkFault("R8 fault from idle");
    prevReq = 1; blkSensor = 1; #1;
    chk(prevAck == 0, "R8 no ack in fault", prevAck, 0);
    tick(); tick();
    prevReq = 0; blkSensor = 0;
    chkFault("R8 fault sticky");

    // R8 fault during offer withdraws request
    doReset(8);
    motion(0, 1, 1, 1, 1, "R1 homing");
    takeBlock();
    doorClosed = 1; tick(); doorClosed = 0;
    motion(0, 1, 0, 2, 0, "R4 push");
    for (int i = 0; i < MOLD; i++) tick();
    motion(0, 1, 0, 1, 0, "R5 retract");
    motion(0, 0, 1, 0, 2, "R6 open");
    chk(xferReq == 1, "R6 offering", xferReq, 1);
    faultIn = 1; tick(); faultIn = 0;
    chk(xferReq == 0, "R8 offer dropped on fault", xferReq, 0);
    chkFault("R8 fault from offer");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule